// File: doc/BRIEF.md
# Motor Speed Discriminator with Lock Flag

This block judges whether a motor turns too fast or too slow. It counts reference ticks across one period of the motor's frequency-generator (FG) pulse train and compares that count with a target. Two select pins choose the target. The result comes out as an accelerate/decelerate level and an active-low lock flag. A one-cycle strobe marks each new result. The reference ticks come from a voltage-controlled oscillator, which is modelled here as a digital strobe.

FG edges arrive as single-cycle strobes, and the block uses them in alternating roles. One edge opens a measurement window and the next edge closes it. The period after a closing edge is not measured. A fresh verdict therefore appears once every two FG periods. The block also tells the oscillator loop which divisor goes with the chosen target. When the enable is low, the block is in the stop state. It forgets any measurement in progress and shows "decelerate, not locked".

Top module: `spd_disc_lock`

## Requirements
- R1: The count target follows the selects (1 = pin high or left open). With `sel_n1`=1, the target is TGT_HI whatever `sel_n2` is. With `sel_n1`=0 and `sel_n2`=1, it is TGT_LO. With both 0, it is TGT_MID.
- R2: `vco_div` shows the oscillator divisor. With both selects 1 it is TGT_HI. With `sel_n1`=1 and `sel_n2`=0 it is TGT_MID, which gives half speed at the same clock. With `sel_n1`=0 and `sel_n2`=1 it is TGT_LO. With both 0 it is TGT_MID.
- R3: The measured value counts `ref_tick` strobes in the cycles after the opening edge, up to and including the closing-edge cycle. A tick in the opening-edge cycle is not counted. The counter is clog2(TGT_HI)+2 bits wide and holds at all ones rather than wrapping.
- R4: `dout` is 1 (accelerate) when measured >= target. It is 0 (decelerate) when measured < target.
- R5: `ld_n` is 0 when target - target/16 <= measured <= target + target/16, with both ends inclusive and the division truncating. Otherwise `ld_n` is 1.
- R6: Enabled FG edges alternate between opening and closing a window, and the first edge after reset or enable opens one. `upd` is 1 for exactly the one cycle after a closing edge and is never 1 after an opening edge. `dout` and `ld_n` take their new values in that same cycle.
- R7: Between updates, `dout` and `ld_n` hold their values while enabled.
- R8: One cycle after `en` is sampled low, `dout`=0, `ld_n`=1 and `upd`=0. Any open window is dropped, so the first edge after re-enable opens a new window.
- R9: During and right after reset, `dout`=0, `ld_n`=1 and `upd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable (low = stop state) |
| fg_edge | input | 1 | One-cycle strobe per FG edge |
| ref_tick | input | 1 | One-cycle reference oscillator tick |
| sel_n1 | input | 1 | Target select 1 (1 = high/open) |
| sel_n2 | input | 1 | Target select 2 (1 = high/open) |
| dout | output | 1 | 1 = accelerate, 0 = decelerate |
| ld_n | output | 1 | Active-low speed lock flag |
| upd | output | 1 | One-cycle new-result strobe |
| vco_div | output | clog2(TGT_HI)+1 | Divisor for the oscillator loop |

## Verification
The bench uses small targets (64/32/16). For each select combination it sweeps the window length from one tick to past the upper lock bound. This shows the exact tick at which the accelerate verdict flips and both edges of the lock window. A window far longer than the counter range tells saturation apart from wrap-around. A window with no ticks checks the other extreme. A free-running FG edge train, a long idle gap after an update, and a stop in the middle of a window check that edges alternate, that results hold, and that the stop state drops the open window.

// File: rtl/spdd_pkg.sv
package spdd_pkg;

  // 2'b{n1,n2}; 1 means pin high or open
  function automatic int unsigned pick_target(input logic n1, input logic n2,
                                              input int unsigned hi,
                                              input int unsigned mid,
                                              input int unsigned lo);
    if (n1) return hi;
    if (n2) return lo;
    return mid;
  endfunction

  function automatic int unsigned pick_divisor(input logic n1, input logic n2,
                                               input int unsigned hi,
                                               input int unsigned mid,
                                               input int unsigned lo);
    if (n1 && n2)  return hi;
    if (n1)        return mid;
    if (n2)        return lo;
    return mid;
  endfunction

  function automatic int unsigned lock_margin(input int unsigned tgt);
    return tgt >> 4;
  endfunction

  function automatic logic in_lock_window(input int unsigned m,
                                          input int unsigned tgt);
    int unsigned w;
    w = lock_margin(tgt);
    return (m + w >= tgt) && (m <= tgt + w);
  endfunction

endpackage

// File: rtl/spdd_sel.sv
module spdd_sel #(
  parameter int unsigned TGT_HI  = 1024,
  parameter int unsigned TGT_MID = 512,
  parameter int unsigned TGT_LO  = 256,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned DIV_W   = 11
) (
  input  logic             sel_n1,
  input  logic             sel_n2,
  output logic [CNT_W-1:0] target,
  output logic [DIV_W-1:0] div_val
);
  int unsigned t_full, d_full;

  always_comb begin
    t_full  = spdd_pkg::pick_target(sel_n1, sel_n2, TGT_HI, TGT_MID, TGT_LO);
    d_full  = spdd_pkg::pick_divisor(sel_n1, sel_n2, TGT_HI, TGT_MID, TGT_LO);
    target  = t_full[CNT_W-1:0];
    div_val = d_full[DIV_W-1:0];
  end
endmodule

// File: rtl/spdd_period_ctr.sv
module spdd_period_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fg_edge,
  input  logic             ref_tick,
  output logic             armed,
  output logic             close_ev,
  output logic [CNT_W-1:0] meas
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             open_ev;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc  = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
  assign open_ev  = en && fg_edge && !armed;
  assign close_ev = en && fg_edge && armed;
  // value as seen at the closing edge, including a coincident tick
  assign meas     = ref_tick ? cnt_inc : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!en) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (open_ev) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (close_ev) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && ref_tick) begin
      cnt   <= cnt_inc;
    end
  end
endmodule

// File: rtl/spdd_judge.sv
module spdd_judge #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             close_ev,
  input  logic [CNT_W-1:0] meas,
  input  logic [CNT_W-1:0] target,
  output logic             dout,
  output logic             ld_n,
  output logic             upd
);
  int unsigned m_u, t_u;
  logic        too_slow, locked;

  always_comb begin
    m_u      = 32'(meas);
    t_u      = 32'(target);
    too_slow = (m_u >= t_u);
    locked   = spdd_pkg::in_lock_window(m_u, t_u);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      ld_n <= 1'b1;
      upd  <= 1'b0;
    end else if (!en) begin
      dout <= 1'b0;
      ld_n <= 1'b1;
      upd  <= 1'b0;
    end else begin
      upd <= close_ev;
      if (close_ev) begin
        dout <= too_slow;
        ld_n <= !locked;
      end
    end
  end
endmodule

// File: rtl/spd_disc_lock.sv
module spd_disc_lock #(
  parameter int unsigned TGT_HI  = 1024,
  parameter int unsigned TGT_MID = 512,
  parameter int unsigned TGT_LO  = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        fg_edge,
  input  logic                        ref_tick,
  input  logic                        sel_n1,
  input  logic                        sel_n2,
  output logic                        dout,
  output logic                        ld_n,
  output logic                        upd,
  output logic [$clog2(TGT_HI):0]     vco_div
);
  localparam int unsigned CNT_W = $clog2(TGT_HI) + 2;
  localparam int unsigned DIV_W = $clog2(TGT_HI) + 1;

  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] meas;
  logic             close_ev;
  logic             armed;

  spdd_sel #(
    .TGT_HI(TGT_HI), .TGT_MID(TGT_MID), .TGT_LO(TGT_LO),
    .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) u_sel (
    .sel_n1 (sel_n1),
    .sel_n2 (sel_n2),
    .target (target),
    .div_val(vco_div)
  );

  spdd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fg_edge (fg_edge),
    .ref_tick(ref_tick),
    .armed   (armed),
    .close_ev(close_ev),
    .meas    (meas)
  );

  spdd_judge #(.CNT_W(CNT_W)) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .close_ev(close_ev),
    .meas    (meas),
    .target  (target),
    .dout    (dout),
    .ld_n    (ld_n),
    .upd     (upd)
  );
endmodule

// File: rtl/spdd_chk.sv
module spdd_chk #(
  parameter int unsigned DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             fg_edge,
  input logic             close_ev,
  input logic             dout,
  input logic             ld_n,
  input logic             upd,
  input logic [DIV_W-1:0] vco_div
);
  logic opened_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          opened_seen <= 1'b0;
    else if (!en)        opened_seen <= 1'b0;
    else if (close_ev)   opened_seen <= 1'b0;
    else if (fg_edge)    opened_seen <= 1'b1;
  end

  // R6
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R6
  upd_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(close_ev));

  // R6
  close_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_ev |-> opened_seen);

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!upd && !dout && ld_n));

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !upd) |-> ($stable(dout) && $stable(ld_n)));

  // R2
  div_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vco_div) == 1);
endmodule

bind spd_disc_lock spdd_chk #(.DIV_W($clog2(TGT_HI) + 1)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .fg_edge (fg_edge),
  .close_ev(close_ev),
  .dout    (dout),
  .ld_n    (ld_n),
  .upd     (upd),
  .vco_div (vco_div)
);

// File: tb/spd_disc_lock_bench.sv
module spd_disc_lock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HI  = 64;
  localparam int MID = 32;
  localparam int LO  = 16;
  localparam int CTR_TOP = (1 << ($clog2(HI) + 2)) - 1;

  logic clk = 0, rst_n = 0, en = 0, fg_edge = 0, ref_tick = 1;
  logic sel_n1 = 1, sel_n2 = 1;
  logic dout, ld_n, upd;
  logic [$clog2(HI):0] vco_div;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_disc_lock #(.TGT_HI(HI), .TGT_MID(MID), .TGT_LO(LO)) u_spd_disc_lock (
    .clk(clk), .rst_n(rst_n), .en(en), .fg_edge(fg_edge), .ref_tick(ref_tick),
    .sel_n1(sel_n1), .sel_n2(sel_n2), .dout(dout), .ld_n(ld_n), .upd(upd),
    .vco_div(vco_div)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int want_target(input bit a, input bit b);
    case ({a, b})
      2'b11: return HI;
      2'b10: return HI;
      2'b01: return LO;
      default: return MID;
    endcase
  endfunction

  function automatic int want_div(input bit a, input bit b);
    case ({a, b})
      2'b11: return HI;
      2'b10: return MID;
      2'b01: return LO;
      default: return MID;
    endcase
  endfunction

  // one opening edge, closing edge p cycles later; ticks per ref_tick level
  task automatic measure(input int p, input int ticks);
    int t, w, m;
    @(negedge clk) fg_edge = 1;
    @(negedge clk) fg_edge = 0;
    check("R6 no upd on opening edge", upd, 0);
    repeat (p - 1) @(negedge clk);
    fg_edge = 1;
    @(negedge clk) fg_edge = 0;
    t = want_target(sel_n1, sel_n2);
    w = t / 16;
    m = (ticks > CTR_TOP) ? CTR_TOP : ticks;
    check("R6 upd after closing edge", upd, 1);
    check($sformatf("R4 dout p=%0d t=%0d", p, t), dout, (m >= t) ? 1 : 0);
    check($sformatf("R5 ld_n p=%0d t=%0d", p, t), ld_n,
          (m >= t - w && m <= t + w) ? 0 : 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    int seen;
    logic d0, l0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 dout in reset", dout, 0);
    check("R9 ld_n in reset", ld_n, 1);
    check("R9 upd in reset", upd, 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 ld_n after reset", ld_n, 1);
    en = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 sweep over all select combinations and window lengths
    for (int s = 0; s < 4; s++) begin
      int t;
      sel_n1 = s[1];
      sel_n2 = s[0];
      #1;
      check($sformatf("R2 vco_div sel=%0d", s), int'(vco_div), want_div(sel_n1, sel_n2));
      t = want_target(sel_n1, sel_n2);
      for (int p = 1; p <= t + t / 16 + 3; p++) measure(p, p);
    end

    // R3 saturation instead of wrap
    sel_n1 = 1; sel_n2 = 1;
    measure(CTR_TOP + 45, CTR_TOP + 45);

    // R3 no ticks at all
    ref_tick = 0;
    measure(20, 0);
    ref_tick = 1;

    // R7 hold over an idle gap
    measure(HI, HI);
    d0 = dout; l0 = ld_n;
    repeat (50) @(negedge clk);
    check("R7 dout held", dout, d0);
    check("R7 ld_n held", ld_n, l0);
    check("R7 no stray upd", upd, 0);

    // R6 free-running edge train: 6 edges -> 3 updates
    seen = 0;
    for (int e = 0; e < 6; e++) begin
      @(negedge clk) fg_edge = 1;
      @(negedge clk) fg_edge = 0;
      seen += upd;
      repeat (8) @(negedge clk);
    end
    check("R6 updates per 6 edges", seen, 3);

    // R8 stop mid-window drops it
    @(negedge clk) fg_edge = 1;
    @(negedge clk) fg_edge = 0;
    repeat (10) @(negedge clk);
    en = 0;
    @(negedge clk);
    check("R8 dout when stopped", dout, 0);
    check("R8 ld_n when stopped", ld_n, 1);
    check("R8 upd when stopped", upd, 0);
    @(negedge clk) fg_edge = 1;
    @(negedge clk) fg_edge = 0;
    check("R8 edge ignored while stopped", upd, 0);
    en = 1;
    measure(HI, HI);

    finished = 1;
    finish_run();
  end
endmodule